// File: doc/BRIEF.md
# T1 Frame-Locked Line Clock Generator

This block turns a 12.352 MHz master clock into a 1.544 MHz T1 line clock and keeps it aligned to an external 8 kHz frame reference. A divide-by-8 stage makes the line clock. A divide-by-193 stage counts line-clock periods and forms the local frame. Once per frame, the master-clock position of the local frame is compared with the falling edge of the reference. If that edge lands outside a small dead band, the current divide-by-8 period is stretched or shortened by one master cycle.

Reference jitter and wander that stay inside the dead band are ignored. A frame with no reference edge leaves the loop running at the nominal ratio. The first reference edge after reset sets the frame position directly instead of walking toward it.

A mode input turns off the loop and makes the block a plain frame divider. In this mode it counts rising edges of an external 1.544 MHz or 2.048 MHz clock by 193 or 256, and the 8 kHz output comes from that count.

Top module: `t1_frame_pll`

## Requirements
- R1: While `rst` is high at a rising clock edge, all counters and the phase state clear. After that edge `t1ClkOut` is 1 and `frame8kOut` is 0.
- R2: With no correction, `t1ClkOut` has a period of 8 master cycles. It is high for steps 0 to 3 of the divide-by-8 count and low for steps 4 to 7.
- R3: With `modeSel[1]`=0, `frame8kOut` has a period of 1544 master cycles. It is low while the line-clock count is 0 to 96 and high while it is 97 to 192.
- R4: The first edge at which `framePulseIn` is sampled low after being sampled high is the first reference edge after reset. It sets the frame position to 1: line count 0, step 1. Later edges never realign the frame directly.
- R5: The frame position is line count × 8 + step. If it is 0, 1, 1542 or 1543 at a later reference edge, no correction is made.
- R6: If the frame position at a later reference edge is 2 to 771, the position holds for that one cycle. That divide-by-8 period is lengthened by one master cycle.
- R7: If the frame position at a later reference edge is 772 to 1541, the position advances by two in that cycle. That divide-by-8 period is shortened by one master cycle.
- R8: With no reference edge, the loop free-runs at exactly 1544 master cycles per frame and keeps its phase.
- R9: With `modeSel[1]`=1, reference edges cause no correction and no alignment. `t1ClkOut` keeps running unchanged.
- R10: With `modeSel[1]`=1, each sampled rising edge of `extClkIn` advances a divider that wraps after 193 counts when `modeSel[0]`=0 and after 256 counts when `modeSel[0]`=1. `frame8kOut` is 0 while the count is below 97 (or 128) and 1 from there on.
- R11: While `modeSel[1]`=0 the external divider count is held at zero, so each entry into divide mode starts a fresh division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12.352 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| framePulseIn | input | 1 | 8 kHz reference; its falling edge is tracked |
| extClkIn | input | 1 | External 1.544/2.048 MHz clock for divide mode |
| modeSel | input | 2 | Bit 1: 0 = locked loop, 1 = divider; bit 0: divide ratio 193 or 256 |
| t1ClkOut | output | 1 | 1.544 MHz line clock |
| frame8kOut | output | 1 | 8 kHz frame output (local frame or external division) |

## Verification
The assertions assume that `framePulseIn`, `extClkIn` and `modeSel` are already synchronous to the master clock, since the block samples each of them with a single register. They also assume that `extClkIn` stays at one level for at least one master cycle between toggles. The stimulus changes every input only on the falling clock edge. The external clock uses half-periods of three to five master cycles. Reference periods are either near nominal or deliberately offset by a few cycles, so that the dead band, the lengthening zone and the shortening zone are each reached with and without a reference.

// File: rtl/t1pll_pkg.sv
package t1pll_pkg;
  // Strobes from the phase control to the counter datapath
  typedef struct packed {
    logic align;    // first reference edge: load frame position 1
    logic hold;     // lengthen current divide-by-8 period
    logic skip;     // shorten current divide-by-8 period
    logic extTick;  // sampled rising edge of the external clock
    logic divMode;  // plain divider mode active
    logic divWide;  // divider ratio select: wide (1) or narrow (0)
  } pllStrobe_t;
endpackage

// File: rtl/t1pll_ctrl.sv
module t1pll_ctrl
  import t1pll_pkg::*;
#(
  parameter int MASTER_DIV = 8,
  parameter int FRAME_DIV  = 193,
  parameter int WINDOW     = 4,
  localparam int CYC_W  = $clog2(MASTER_DIV),
  localparam int BIT_W  = $clog2(FRAME_DIV)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             framePulseIn,
  input  logic             extClkIn,
  input  logic [1:0]       modeSel,
  input  logic [CYC_W-1:0] cycCnt,
  input  logic [BIT_W-1:0] bitCnt,
  output pllStrobe_t       strobe
);
  localparam int TOTAL   = MASTER_DIV * FRAME_DIV;
  localparam int POS_W   = $clog2(TOTAL);
  localparam int HALF_T  = TOTAL / 2;
  localparam int LO_EDGE = WINDOW / 2;
  localparam int HI_EDGE = TOTAL - (WINDOW - LO_EDGE);

  logic refD, extD, aligned;
  logic refFall, normalMode, aheadZone, behindZone;
  logic [POS_W-1:0] framePos;

  always_comb begin
    framePos   = POS_W'(bitCnt) * POS_W'(MASTER_DIV) + POS_W'(cycCnt);
    refFall    = refD & ~framePulseIn;
    normalMode = ~modeSel[1];
    aheadZone  = (framePos >= POS_W'(LO_EDGE)) && (framePos < POS_W'(HALF_T));
    behindZone = (framePos >= POS_W'(HALF_T)) && (framePos < POS_W'(HI_EDGE));
    strobe.align   = normalMode & refFall & ~aligned;
    strobe.hold    = normalMode & refFall & aligned & aheadZone;
    strobe.skip    = normalMode & refFall & aligned & behindZone;
    strobe.extTick = extClkIn & ~extD;
    strobe.divMode = modeSel[1];
    strobe.divWide = modeSel[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refD    <= 1'b0;
      extD    <= 1'b0;
      aligned <= 1'b0;
    end else begin
      refD <= framePulseIn;
      extD <= extClkIn;
      if (strobe.align) aligned <= 1'b1;
    end
  end

  // R9
  div_no_corr_chk: assert property (@(posedge clk) disable iff (rst)
    modeSel[1] |-> !(strobe.hold || strobe.skip || strobe.align));
  // R4
  align_once_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.align |=> !strobe.align && aligned);
  // R5
  window_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (refFall && aligned && (framePos < POS_W'(LO_EDGE) || framePos >= POS_W'(HI_EDGE)))
      |-> !(strobe.hold || strobe.skip));
endmodule

// File: rtl/t1pll_datapath.sv
module t1pll_datapath
  import t1pll_pkg::*;
#(
  parameter int MASTER_DIV = 8,
  parameter int FRAME_DIV  = 193,
  parameter int DIV_NARROW = 193,
  parameter int DIV_WIDE   = 256,
  localparam int CYC_W = $clog2(MASTER_DIV),
  localparam int BIT_W = $clog2(FRAME_DIV)
) (
  input  logic             clk,
  input  logic             rst,
  input  pllStrobe_t       strobe,
  output logic [CYC_W-1:0] cycCnt,
  output logic [BIT_W-1:0] bitCnt,
  output logic             t1ClkOut,
  output logic             frame8kOut
);
  localparam int DIV_W = $clog2(DIV_WIDE);
  localparam int SUM_W = CYC_W + 1;

  logic [SUM_W-1:0] cycSum;
  logic             cycWrap;
  logic [CYC_W-1:0] cycNext;
  logic [BIT_W-1:0] bitNext;
  logic [DIV_W-1:0] divCnt, divLimit, divHalf;

  always_comb begin
    cycSum  = {1'b0, cycCnt} + (strobe.skip ? SUM_W'(2) : SUM_W'(1));
    cycWrap = cycSum >= SUM_W'(MASTER_DIV);
    cycNext = cycWrap ? CYC_W'(cycSum - SUM_W'(MASTER_DIV)) : CYC_W'(cycSum);
    if (!cycWrap)                              bitNext = bitCnt;
    else if (bitCnt == BIT_W'(FRAME_DIV - 1))  bitNext = '0;
    else                                       bitNext = bitCnt + 1'b1;
    divLimit = strobe.divWide ? DIV_W'(DIV_WIDE - 1) : DIV_W'(DIV_NARROW - 1);
    divHalf  = strobe.divWide ? DIV_W'((DIV_WIDE + 1) / 2) : DIV_W'((DIV_NARROW + 1) / 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cycCnt <= '0;
      bitCnt <= '0;
    end else if (strobe.align) begin
      cycCnt <= CYC_W'(1);
      bitCnt <= '0;
    end else if (!strobe.hold) begin
      cycCnt <= cycNext;
      bitCnt <= bitNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.divMode)  divCnt <= '0;
    else if (strobe.extTick)     divCnt <= (divCnt >= divLimit) ? '0 : divCnt + 1'b1;
  end

  assign t1ClkOut   = cycCnt < CYC_W'(MASTER_DIV / 2);
  assign frame8kOut = strobe.divMode ? (divCnt >= divHalf)
                                     : (bitCnt >= BIT_W'((FRAME_DIV + 1) / 2));

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.hold |=> $stable(cycCnt) && $stable(bitCnt));
  // R7
  skip_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.skip && cycCnt < CYC_W'(MASTER_DIV - 2)) |=> cycCnt == $past(cycCnt) + CYC_W'(2));
  // R4
  align_phase_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.align |=> (cycCnt == CYC_W'(1)) && (bitCnt == '0));
  // R11
  div_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.divMode |=> divCnt == '0);
  // R8
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cycCnt == CYC_W'(MASTER_DIV - 1) && bitCnt == BIT_W'(FRAME_DIV - 1)
      && !strobe.hold && !strobe.skip && !strobe.align) |=> (cycCnt == '0 && bitCnt == '0));
endmodule

// File: rtl/t1_frame_pll.sv
module t1_frame_pll
  import t1pll_pkg::*;
#(
  parameter int MASTER_DIV = 8,
  parameter int FRAME_DIV  = 193,
  parameter int WINDOW     = 4,
  parameter int DIV_NARROW = 193,
  parameter int DIV_WIDE   = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       framePulseIn,
  input  logic       extClkIn,
  input  logic [1:0] modeSel,
  output logic       t1ClkOut,
  output logic       frame8kOut
);
  localparam int CYC_W = $clog2(MASTER_DIV);
  localparam int BIT_W = $clog2(FRAME_DIV);

  pllStrobe_t       strobe;
  logic [CYC_W-1:0] cycCnt;
  logic [BIT_W-1:0] bitCnt;

  t1pll_ctrl #(
    .MASTER_DIV(MASTER_DIV), .FRAME_DIV(FRAME_DIV), .WINDOW(WINDOW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .framePulseIn(framePulseIn), .extClkIn(extClkIn),
    .modeSel(modeSel), .cycCnt(cycCnt), .bitCnt(bitCnt), .strobe(strobe)
  );

  t1pll_datapath #(
    .MASTER_DIV(MASTER_DIV), .FRAME_DIV(FRAME_DIV),
    .DIV_NARROW(DIV_NARROW), .DIV_WIDE(DIV_WIDE)
  ) u_datapath (
    .clk(clk), .rst(rst), .strobe(strobe), .cycCnt(cycCnt), .bitCnt(bitCnt),
    .t1ClkOut(t1ClkOut), .frame8kOut(frame8kOut)
  );
endmodule

// File: tb/t1_frame_pll_bench.sv
module t1_frame_pll_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic framePulseIn = 1'b1;
  logic extClkIn = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic t1ClkOut, frame8kOut;

  always #2 clk = ~clk;  // 250 MHz

  t1_frame_pll u_t1_frame_pll (
    .clk(clk), .rst(rst), .framePulseIn(framePulseIn), .extClkIn(extClkIn),
    .modeSel(modeSel), .t1ClkOut(t1ClkOut), .frame8kOut(frame8kOut)
  );

  int    nCompared = 0;
  int    nMismatch = 0;
  string curReq = "R1";
  bit    checking = 1'b0;
  bit    done = 1'b0;

  // Requirement-level expectation state
  int mPos, mDiv;
  bit mRefD, mExtD, mAligned;

  function automatic bit expT1(int pos);
    return (pos % 8) < 4;                      // R2
  endfunction

  function automatic bit expFrame(int pos, int div, logic [1:0] mode);
    int lim;
    lim = mode[0] ? 256 : 193;
    if (mode[1]) return div >= (lim + 1) / 2;  // R10
    return (pos / 8) >= 97;                    // R3
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPos = 0; mDiv = 0; mRefD = 0; mExtD = 0; mAligned = 0;
    end else begin
      bit fall, rise, norm;
      int lim;
      fall = mRefD && !framePulseIn;
      rise = extClkIn && !mExtD;
      norm = !modeSel[1];
      lim  = modeSel[0] ? 256 : 193;
      if (norm && fall && !mAligned) begin mPos = 1; mAligned = 1; end          // R4
      else if (norm && fall && mPos >= 2 && mPos < 772) begin end               // R6
      else if (norm && fall && mPos >= 772 && mPos < 1542) mPos = (mPos + 2) % 1544; // R7
      else mPos = (mPos + 1) % 1544;                                            // R5, R8
      if (!norm) begin
        if (rise) mDiv = (mDiv >= lim - 1) ? 0 : mDiv + 1;
      end else mDiv = 0;                                                        // R11
      mRefD = framePulseIn;
      mExtD = extClkIn;
    end
  end

  task automatic check(string req, logic act, logic exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (checking && !rst) begin
      check(modeSel[1] ? "R9" : "R2", t1ClkOut, expT1(mPos));
      check(curReq, frame8kOut, expFrame(mPos, mDiv, modeSel));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic refFrame(int per);
    framePulseIn = 1'b1;
    repeat (per - 100) @(negedge clk);
    framePulseIn = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  task automatic extRun(int n);
    int left;
    left = n;
    while (left > 0) begin
      int half;
      half = $urandom_range(3, 5);
      extClkIn = ~extClkIn;
      repeat (half) @(negedge clk);
      left -= half;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    idle(4);
    // R1: state while reset is held
    @(posedge clk); #1;
    check("R1", t1ClkOut, 1'b1);
    check("R1", frame8kOut, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    checking = 1'b1;

    curReq = "R3";  idle(3200);                 // free-run before any reference
    curReq = "R4";  repeat (3) refFrame(1544);  // first edge aligns directly
    curReq = "R5";
    repeat (6) refFrame(1543 + $urandom_range(0, 2));
    repeat (2) refFrame(1544);
    curReq = "R6";  refFrame(1550); repeat (6) refFrame(1544);
    curReq = "R7";  refFrame(1538); repeat (6) refFrame(1544);
    curReq = "R5";  refFrame(1545); refFrame(1543);
    curReq = "R8";  framePulseIn = 1'b1; idle(3200);

    curReq = "R10"; modeSel = 2'b10;
    fork
      extRun(3300);
      begin refFrame(1550); refFrame(1537); end
    join
    modeSel = 2'b11;
    fork
      extRun(4400);
      begin refFrame(1550); refFrame(1537); end
    join
    curReq = "R11"; modeSel = 2'b00; extClkIn = 1'b0;
    repeat (2) refFrame(1544);
    modeSel = 2'b10; extRun(900);
    modeSel = 2'b00; idle(20);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nMismatch++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule